// File: doc/BRIEF.md
# SPI-to-NAND Bridge with Output Expander

This block is an SPI slave that lets a host drive a parallel 8-bit NAND flash device and a handful of board outputs. Every chip-select frame begins with a one-byte opcode sent on a single data line. The opcode selects one of four actions:

- write bytes to the NAND with a write strobe;
- read bytes from the NAND with a read strobe and return them on the slave output line;
- load an 8-bit configuration byte;
- switch a fifth LED on or off.

The configuration byte holds the NAND address-latch and command-latch enables, the active-low NAND chip enable, four LEDs and a fan enable. NAND command and address cycles are therefore ordinary one-byte write frames, sent while the command-latch or address-latch bit is set.

All SPI pins are sampled in the system clock domain, so SCK must be slow compared with the system clock. NAND write payloads arrive two bits per SCK edge on two data lines. Each write frame ends with one trailer byte that is never written to the NAND. Read data is fetched one byte ahead of the host, so that its MSB is on the output line before the first SCK rise of each byte.

Top module: `spi_nand_bridge`

## Requirements
- R1: After reset the fan, the address latch, the command latch and all five LEDs are low, the NAND chip enable is high (deasserted), both NAND strobes are high, the NAND bus is not driven and `spi_miso` is low.
- R2: Opcode 0x09 loads the following byte as the configuration. Bit 0 drives LED1 (`led[0]`), bit 1 drives LED3 (`led[2]`), bit 2 drives LED2 (`led[1]`), bit 3 drives LED4 (`led[3]`), bit 4 drives `fan_en`, bit 5 drives `nand_ale`, bit 6 drives `nand_cle`, and bit 7 drives `nand_ce_n` unchanged, so a 0 selects the NAND.
- R3: In a configuration frame only the first byte after the opcode is used; later bytes in that frame change no output.
- R4: Opcode 0x08 starts a write frame. Each later byte arrives as four SCK rises carrying two bits each: `spi_io1` holds the more significant bit of the pair, and the most significant pair comes first. Every such byte except the last byte of the frame (the trailer) is written to the NAND with one write strobe, in arrival order.
- R5: A write strobe carries the address-latch, command-latch and chip-enable values that the configuration holds at that time, so a one-byte write frame issued with bit 6 or bit 5 set forms a command or address cycle.
- R6: Opcode 0x0A starts a read frame. The first byte after the opcode is filler. Every later byte shifts out on `spi_miso`, MSB first, the next NAND byte. One read strobe is issued when the filler completes and one each time a read byte completes, so a frame with N read bytes issues N+1 read strobes.
- R7: Opcode 0x0B is a read frame with no filler byte: the first read strobe is issued when the opcode completes.
- R8: Opcode 0x0C sets LED5 (`led[4]`) and opcode 0x0D clears it; neither changes any other output.
- R9: Any other opcode is ignored: the rest of its frame produces no NAND strobe and no output change.
- R10: Raising chip select drops any partial byte. The next frame starts again with an opcode, and a configuration byte cut short by chip select leaves the outputs unchanged.
- R11: Each NAND strobe stays low for at least STROBE_CYC system clocks. Write data is driven at least one clock before the write strobe falls, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sck | input | 1 | SPI clock from the host, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low, frames a command |
| spi_io0 | input | 1 | Host data line 0; the single line for opcodes and other bytes |
| spi_io1 | input | 1 | Host data line 1; the upper bit of each pair in write payloads |
| spi_miso | output | 1 | Read data returned to the host, MSB first |
| nand_dq_o | output | 8 | Data driven toward the NAND |
| nand_dq_i | input | 8 | Data returned by the NAND |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_ale | output | 1 | NAND address latch enable |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| fan_en | output | 1 | Fan enable |
| led | output | 5 | LED1..LED5 on bits 0..4 |

## Verification
The hardest case to reach is the switch from single-line to two-line sampling in the middle of a write frame. A write is only released when the byte after it arrives, so a wrong trailer or a wrong bit order shows only as a missing, extra or scrambled strobe. The stimulus sends write frames with one to four payload bytes, each under a different latch setting. A scoreboard queues every expected write with its latch state and compares entries as the write strobes rise; a queue that is not empty after the frame, or a strobe with no queued entry, marks a trailer that was wrongly handled. Chip select is also raised in mid-opcode and in mid-configuration byte to reach the abort paths.

// File: rtl/snb_pkg.sv
package snb_pkg;

  localparam int BYTE_W = 8;

  // Command opcodes
  localparam logic [7:0] OPC_NAND_WR   = 8'h08;
  localparam logic [7:0] OPC_CFG_WR    = 8'h09;
  localparam logic [7:0] OPC_NAND_RD   = 8'h0A;
  localparam logic [7:0] OPC_NAND_RDF  = 8'h0B;
  localparam logic [7:0] OPC_LED5_SET  = 8'h0C;
  localparam logic [7:0] OPC_LED5_CLR  = 8'h0D;

  // Configuration bit positions (host software depends on these)
  localparam int CB_LED1 = 0;
  localparam int CB_LED3 = 1;
  localparam int CB_LED2 = 2;
  localparam int CB_LED4 = 3;
  localparam int CB_FAN  = 4;
  localparam int CB_ALE  = 5;
  localparam int CB_CLE  = 6;
  localparam int CB_CEN  = 7;

  localparam logic [BYTE_W-1:0] CFG_RST = 8'h80;

  typedef enum logic [2:0] {
    FR_OPCODE,
    FR_WRITE,
    FR_CFG,
    FR_RD_PAD,
    FR_READ,
    FR_SKIP
  } frame_st_e;

  typedef enum logic [1:0] {
    SB_IDLE,
    SB_SETUP,
    SB_LOW,
    SB_HOLD
  } strobe_st_e;

endpackage

// File: rtl/snb_sync.sv
module snb_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/snb_rx.sv
module snb_rx
  import snb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              io0,
  input  logic              io1,
  input  logic              dual,
  output logic              byte_v,
  output logic [BYTE_W-1:0] byte_d,
  output logic              sck_fall,
  output logic              at_bound
);

  localparam logic [3:0] BITS_FULL = 4'(BYTE_W);

  logic              sck_q;
  logic              rise;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d;
  logic              bv_d;
  logic              sr_en;

  assign rise     = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    sr_en = 1'b0;
    bv_d  = 1'b0;
    if (cs_n) begin
      cnt_d = '0;
    end else if (rise) begin
      sr_en = 1'b1;
      if (dual) begin
        sr_d  = {sr_q[BYTE_W-3:0], io1, io0};
        cnt_d = cnt_q + 4'd2;
      end else begin
        sr_d  = {sr_q[BYTE_W-2:0], io0};
        cnt_d = cnt_q + 4'd1;
      end
      if (cnt_d == BITS_FULL) begin
        bv_d  = 1'b1;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      byte_v <= 1'b0;
    end else begin
      sck_q  <= sck;
      cnt_q  <= cnt_d;
      byte_v <= bv_d;
      if (sr_en) sr_q <= sr_d;
    end
  end

  assign byte_d   = sr_q;
  assign at_bound = (cnt_q == 4'd0);

endmodule

// File: rtl/snb_strobe.sv
module snb_strobe
  import snb_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] dq_i,
  output logic [BYTE_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              we_n,
  output logic              re_n,
  output logic [BYTE_W-1:0] rdata,
  output logic              rd_done
);

  localparam int              CNT_W    = $clog2(STROBE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  strobe_st_e        st_q, st_d;
  logic              rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] dq_q;
  logic              dq_en;
  logic [BYTE_W-1:0] rdat_q;
  logic              rdat_en;
  logic              done_d, done_q;

  always_comb begin
    st_d    = st_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    dq_en   = 1'b0;
    rdat_en = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      SB_IDLE: begin
        if (start_wr) begin
          st_d  = SB_SETUP;
          rd_d  = 1'b0;
          dq_en = 1'b1;
        end else if (start_rd) begin
          st_d = SB_SETUP;
          rd_d = 1'b1;
        end
      end
      SB_SETUP: begin
        st_d  = SB_LOW;
        cnt_d = '0;
      end
      SB_LOW: begin
        if (cnt_q == CNT_LAST) begin
          st_d = SB_HOLD;
          if (rd_q) begin
            rdat_en = 1'b1;
            done_d  = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      SB_HOLD: st_d = SB_IDLE;
      default: st_d = SB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SB_IDLE;
      rd_q   <= 1'b0;
      cnt_q  <= '0;
      dq_q   <= '0;
      rdat_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (dq_en)   dq_q   <= wdata;
      if (rdat_en) rdat_q <= dq_i;
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe   = (st_q != SB_IDLE) && !rd_q;
  assign we_n    = !((st_q == SB_LOW) && !rd_q);
  assign re_n    = !((st_q == SB_LOW) && rd_q);
  assign rdata   = rdat_q;
  assign rd_done = done_q;

endmodule

// File: rtl/spi_nand_bridge.sv
module spi_nand_bridge
  import snb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_io0,
  input  logic              spi_io1,
  output logic              spi_miso,
  output logic [BYTE_W-1:0] nand_dq_o,
  input  logic [BYTE_W-1:0] nand_dq_i,
  output logic              nand_dq_oe,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_ce_n,
  output logic              fan_en,
  output logic [4:0]        led
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_q;
  snb_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  // Pin synchronisers: {sck, cs_n, io1, io0}
  logic [3:0] pins_s;
  snb_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_pin_sync (
    .clk(clk), .rst_n(rst_q),
    .d({spi_sck, spi_cs_n, spi_io1, spi_io0}),
    .q(pins_s)
  );

  logic              cs_idle;
  frame_st_e         st_q, st_d;
  logic              byte_v;
  logic [BYTE_W-1:0] byte_d;
  logic              sck_fall;
  logic              at_bound;

  assign cs_idle = pins_s[2];

  snb_rx u_rx (
    .clk(clk), .rst_n(rst_q),
    .sck(pins_s[3]), .cs_n(pins_s[2]), .io0(pins_s[0]), .io1(pins_s[1]),
    .dual(st_q == FR_WRITE),
    .byte_v(byte_v), .byte_d(byte_d),
    .sck_fall(sck_fall), .at_bound(at_bound)
  );

  logic              start_wr, start_rd;
  logic [BYTE_W-1:0] pend_q, pend_d;
  logic              pend_v_q, pend_v_d;
  logic [BYTE_W-1:0] rdata;
  logic              rd_done;

  snb_strobe #(.STROBE_CYC(STROBE_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_q),
    .start_wr(start_wr), .start_rd(start_rd), .wdata(pend_q),
    .dq_i(nand_dq_i), .dq_o(nand_dq_o), .dq_oe(nand_dq_oe),
    .we_n(nand_we_n), .re_n(nand_re_n),
    .rdata(rdata), .rd_done(rd_done)
  );

  // Frame decoder, configuration and LED5
  logic [BYTE_W-1:0] cfg_q, cfg_d;
  logic              cfg_en;
  logic              led5_q, led5_d;

  always_comb begin
    st_d     = st_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    cfg_d    = cfg_q;
    cfg_en   = 1'b0;
    led5_d   = led5_q;
    start_wr = 1'b0;
    start_rd = 1'b0;
    if (cs_idle) begin
      st_d     = FR_OPCODE;
      pend_v_d = 1'b0;
    end else if (byte_v) begin
      unique case (st_q)
        FR_OPCODE: begin
          case (byte_d)
            OPC_NAND_WR:  st_d = FR_WRITE;
            OPC_CFG_WR:   st_d = FR_CFG;
            OPC_NAND_RD:  st_d = FR_RD_PAD;
            OPC_NAND_RDF: begin
              st_d     = FR_READ;
              start_rd = 1'b1;
            end
            OPC_LED5_SET: begin
              st_d   = FR_SKIP;
              led5_d = 1'b1;
            end
            OPC_LED5_CLR: begin
              st_d   = FR_SKIP;
              led5_d = 1'b0;
            end
            default:      st_d = FR_SKIP;
          endcase
        end
        FR_WRITE: begin
          start_wr = pend_v_q;
          pend_d   = byte_d;
          pend_v_d = 1'b1;
        end
        FR_CFG: begin
          cfg_d  = byte_d;
          cfg_en = 1'b1;
          st_d   = FR_SKIP;
        end
        FR_RD_PAD: begin
          start_rd = 1'b1;
          st_d     = FR_READ;
        end
        FR_READ:  start_rd = 1'b1;
        FR_SKIP:  st_d = FR_SKIP;
        default:  st_d = FR_SKIP;
      endcase
    end
  end

  // Read return path
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              tx_en;
  logic              miso_d, miso_q;
  logic              reading;

  assign reading = (st_q == FR_READ);

  always_comb begin
    tx_d  = tx_q;
    tx_en = 1'b0;
    if (rd_done) begin
      tx_d  = rdata;
      tx_en = 1'b1;
    end else if (reading && sck_fall && !at_bound) begin
      tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
      tx_en = 1'b1;
    end
    miso_d = reading & tx_q[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q     <= FR_OPCODE;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      cfg_q    <= CFG_RST;
      led5_q   <= 1'b0;
      tx_q     <= '0;
      miso_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      pend_v_q <= pend_v_d;
      led5_q   <= led5_d;
      miso_q   <= miso_d;
      if (byte_v) pend_q <= pend_d;
      if (cfg_en) cfg_q  <= cfg_d;
      if (tx_en)  tx_q   <= tx_d;
    end
  end

  assign spi_miso  = miso_q;
  assign nand_ale  = cfg_q[CB_ALE];
  assign nand_cle  = cfg_q[CB_CLE];
  assign nand_ce_n = cfg_q[CB_CEN];
  assign fan_en    = cfg_q[CB_FAN];
  assign led       = {led5_q, cfg_q[CB_LED4], cfg_q[CB_LED3], cfg_q[CB_LED2], cfg_q[CB_LED1]};

endmodule

// File: rtl/snb_chk.sv
module snb_chk #(
  parameter int STROBE_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_dq_oe,
  input logic       nand_ale,
  input logic       nand_cle,
  input logic       nand_ce_n,
  input logic       fan_en,
  input logic [4:0] led
);

  logic [7:0] we_lo_cnt, re_lo_cnt, cs_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      re_lo_cnt <= '0;
      cs_hi_cnt <= '0;
    end else begin
      we_lo_cnt <= nand_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      re_lo_cnt <= nand_re_n ? 8'd0 : ((re_lo_cnt == 8'hFF) ? re_lo_cnt : re_lo_cnt + 8'd1);
      cs_hi_cnt <= !spi_cs_n ? 8'd0 : ((cs_hi_cnt == 8'hFF) ? cs_hi_cnt : cs_hi_cnt + 8'd1);
    end
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_we_setup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> $past(nand_dq_oe));

  p_we_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> (we_lo_cnt >= 8'(STROBE_CYC)));

  p_re_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_re_n) |-> (re_lo_cnt >= 8'(STROBE_CYC)));

  p_drive_with_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_cnt >= 8'd16) |-> (nand_we_n && nand_re_n));

  p_quiet_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_cnt >= 8'd4) |=> $stable({nand_ale, nand_cle, nand_ce_n, fan_en, led}));

endmodule

bind spi_nand_bridge snb_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe),
  .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce_n(nand_ce_n),
  .fan_en(fan_en), .led(led)
);

// File: tb/spi_nand_bridge_tb_top.sv
`timescale 1ns/1ps
module spi_nand_bridge_tb_top;

  localparam int HALF = 20;
  localparam int STROBE_CYC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_sck, spi_cs_n, spi_io0, spi_io1;
  logic       spi_miso;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic       nand_dq_oe, nand_we_n, nand_re_n;
  logic       nand_ale, nand_cle, nand_ce_n, fan_en;
  logic [4:0] led;

  always #2 clk = ~clk;

  spi_nand_bridge #(.STROBE_CYC(STROBE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_io0(spi_io0), .spi_io1(spi_io1),
    .spi_miso(spi_miso),
    .nand_dq_o(nand_dq_o), .nand_dq_i(nand_dq_i), .nand_dq_oe(nand_dq_oe),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce_n(nand_ce_n),
    .fan_en(fan_en), .led(led)
  );

  function automatic logic [7:0] nand_byte(input logic [7:0] idx);
    return 8'h5A ^ (idx * 8'd29 + 8'd3);
  endfunction

  // Expected outputs {ce_n, cle, ale, fan, led[4:0]} from config byte and LED5
  function automatic logic [8:0] exp_out(input logic [7:0] c, input logic l5);
    return {c[7], c[6], c[5], c[4], l5, c[3], c[1], c[2], c[0]};
  endfunction

  // Scoreboard and counters
  logic [10:0] wr_q[$];
  int mon_chk = 0, mon_fail = 0;
  int main_chk = 0, main_fail = 0;
  int n_wr = 0, n_rd = 0;
  logic [7:0] rd_ptr = 8'd0;
  logic prev_we = 1'b1, prev_re = 1'b1, prev_oe = 1'b0;
  int we_lo = 0, re_lo = 0;
  bit done = 0;

  assign nand_dq_i = nand_byte(rd_ptr);

  // Monitor: strobe widths, setup, and write scoreboard pops
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (prev_we && !nand_we_n) begin
        mon_chk++;
        if (!prev_oe) begin
          mon_fail++;
          $display("FAIL R11 write data not driven before strobe: actual=%0b expected=1", prev_oe);
        end
      end
      if (!nand_we_n) we_lo++;
      if (!nand_re_n) re_lo++;
      if (!prev_we && nand_we_n) begin
        logic [10:0] got;
        got = {nand_ce_n, nand_cle, nand_ale, nand_dq_o};
        n_wr++;
        mon_chk++;
        if (we_lo < STROBE_CYC) begin
          mon_fail++;
          $display("FAIL R11 write strobe width actual=%0d expected>=%0d", we_lo, STROBE_CYC);
        end
        mon_chk++;
        if (wr_q.size() == 0) begin
          mon_fail++;
          $display("FAIL R4 unexpected write actual=%0h expected=none", got);
        end else begin
          logic [10:0] e;
          e = wr_q.pop_front();
          if (got !== e) begin
            mon_fail++;
            if (e[9] | e[8]) $display("FAIL R5 latch cycle actual=%0h expected=%0h", got, e);
            else             $display("FAIL R4 write data actual=%0h expected=%0h", got, e);
          end
        end
        we_lo = 0;
      end
      if (!prev_re && nand_re_n) begin
        n_rd++;
        mon_chk++;
        if (re_lo < STROBE_CYC) begin
          mon_fail++;
          $display("FAIL R11 read strobe width actual=%0d expected>=%0d", re_lo, STROBE_CYC);
        end
        re_lo = 0;
        rd_ptr <= rd_ptr + 8'd1;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
      prev_oe = nand_dq_oe;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    main_chk++;
    if (act !== exp) begin
      main_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer1(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_io0 = tx[i];
      spi_io1 = 1'b0;
      wait_clk(HALF);
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic xfer2(input logic [7:0] tx);
    for (int k = 0; k < 4; k++) begin
      spi_io1 = tx[7-2*k];
      spi_io0 = tx[6-2*k];
      wait_clk(HALF);
      spi_sck = 1'b1;
      wait_clk(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic fbegin();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic fend();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(4*HALF);
  endtask

  logic [7:0] cur_cfg = 8'h80;
  logic       cur_l5  = 1'b0;
  logic [7:0] dummy;
  logic [7:0] pay[8];
  int exp_rd = 0;

  task automatic cfg_frame(input logic [7:0] c);
    fbegin(); xfer1(8'h09, dummy); xfer1(c, dummy); fend();
    cur_cfg = c;
  endtask

  task automatic wr_frame(input int n, input logic [7:0] trailer);
    for (int i = 0; i < n; i++) wr_q.push_back({cur_cfg[7], cur_cfg[6], cur_cfg[5], pay[i]});
    fbegin();
    xfer1(8'h08, dummy);
    for (int i = 0; i < n; i++) xfer2(pay[i]);
    xfer2(trailer);
    fend();
  endtask

  task automatic rd_frame(input bit fast, input int n, input string req);
    logic [7:0] r;
    int base;
    base = exp_rd;
    fbegin();
    xfer1(fast ? 8'h0B : 8'h0A, dummy);
    if (!fast) xfer1(8'h00, dummy);
    for (int k = 0; k < n; k++) begin
      xfer1(8'h00, r);
      chk(req, r, nand_byte(8'(base + k)));
    end
    fend();
    exp_rd = exp_rd + n + 1;
    chk(req, n_rd, exp_rd);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", main_chk + mon_chk, main_fail + mon_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      main_chk++;
      main_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int wr_before, rd_before;
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_io0 = 1'b0; spi_io1 = 1'b0;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(10);

    // R1 reset state
    chk("R1 outputs", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(8'h80, 1'b0));
    chk("R1 strobes", {nand_we_n, nand_re_n, nand_dq_oe, spi_miso}, 4'b1100);

    // R2 configuration mapping
    cfg_frame(8'h92);
    chk("R2 cfg 0x92", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(8'h92, cur_l5));
    cfg_frame(8'h25);
    chk("R2 cfg 0x25", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(8'h25, cur_l5));

    // R3 only first byte used
    fbegin(); xfer1(8'h09, dummy); xfer1(8'h41, dummy); xfer1(8'hFF, dummy); xfer1(8'h00, dummy); fend();
    cur_cfg = 8'h41;
    chk("R3 extra bytes", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(8'h41, cur_l5));

    // R8 LED5
    fbegin(); xfer1(8'h0C, dummy); fend();
    cur_l5 = 1'b1;
    chk("R8 led5 on", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(cur_cfg, 1'b1));
    fbegin(); xfer1(8'h0D, dummy); fend();
    cur_l5 = 1'b0;
    chk("R8 led5 off", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(cur_cfg, 1'b0));

    // R9 undefined opcode
    wr_before = n_wr; rd_before = n_rd;
    fbegin(); xfer1(8'h3E, dummy); xfer1(8'h12, dummy); xfer1(8'h34, dummy); fend();
    chk("R9 outputs", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(cur_cfg, cur_l5));
    chk("R9 strobes", n_wr + n_rd, wr_before + rd_before);

    // R10 abort mid-opcode and mid-config byte
    fbegin();
    for (int i = 0; i < 4; i++) begin
      spi_io0 = 1'b1; wait_clk(HALF); spi_sck = 1'b1; wait_clk(HALF); spi_sck = 1'b0;
    end
    fend();
    fbegin(); xfer1(8'h09, dummy);
    for (int i = 0; i < 5; i++) begin
      spi_io0 = 1'b1; wait_clk(HALF); spi_sck = 1'b1; wait_clk(HALF); spi_sck = 1'b0;
    end
    fend();
    chk("R10 partial cfg", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(cur_cfg, cur_l5));
    cfg_frame(8'h18);
    chk("R10 realigned", {nand_ce_n, nand_cle, nand_ale, fan_en, led}, exp_out(8'h18, cur_l5));

    // R5 command then address cycles
    cfg_frame(8'h40);
    pay[0] = 8'h70;
    wr_frame(1, 8'hEE);
    chk("R5 cmd queue", wr_q.size(), 0);
    cfg_frame(8'h20);
    pay[0] = 8'h00; pay[1] = 8'h12;
    wr_frame(2, 8'h81);
    chk("R5 addr queue", wr_q.size(), 0);

    // R4 data payload with trailer
    cfg_frame(8'h00);
    wr_before = n_wr;
    pay[0] = 8'hC3; pay[1] = 8'h5A; pay[2] = 8'h81; pay[3] = 8'h3C;
    wr_frame(4, 8'h99);
    chk("R4 queue drained", wr_q.size(), 0);
    chk("R4 trailer dropped", n_wr - wr_before, 4);

    // R6 read with filler, R7 fast read
    rd_frame(1'b0, 3, "R6");
    rd_frame(1'b1, 2, "R7");
    chk("R6 no write during reads", n_wr - wr_before, 4);
    chk("R11 idle strobes", {nand_we_n, nand_re_n}, 2'b11);

    done = 1;
    summary();
    $finish;
  end

endmodule